// File: doc/BRIEF.md
# UART incrementing pattern transmitter

This block drives the transmit line of a serial test instrument. After a start command it sends a programmed number of words. The first word carries a loaded seed value, and each later word carries the previous value plus one, wrapped to the configured data width. The frame shape and the bit period come from configuration inputs that the receive side also reads. The block captures them when the start command is accepted, so later changes do not affect a run in progress.

A run begins with a pause given in nanoseconds, which the block turns into clock cycles using a clock-period parameter. A flag on the start command enables CTS gating instead. In that mode the pause is skipped, and a new frame leaves only when CTS is high at a frame boundary. A stop command ends the run. A frame already on the wire always completes. The busy output shows whether a run is active.

Top module: `uart_seq_tx`

## Requirements
- R1: While reset is asserted and after it is released, `tx_o` is 1 and `busy_o` is 0 until a run is accepted.
- R2: A start pulse is accepted only while `busy_o` is 0 and `cfg_count` is nonzero. `busy_o` rises at the next clock edge. A start with a zero count leaves the block idle, and a start during a run has no effect on the line.
- R3: Without flow control, N = floor(`cfg_delay_ns` / CLK_PERIOD_NS). The start bit of the first frame begins at the (N+1)-th clock edge after the edge that sampled the start pulse.
- R4: A frame is sent LSB first. It has a 0 start bit, then the data bits, then an optional parity bit, then one stop bit (`cfg_two_stop`=0) or two stop bits (`cfg_two_stop`=1) at 1. `cfg_data_bits` 0 selects 7 data bits, 1 selects 8, and 2 or 3 select 9. `cfg_parity` 1 selects odd parity, 2 selects even parity, and 0 or 3 select no parity. Each bit lasts `cfg_baud_div` clocks, and a value of 0 counts as 1.
- R5: The first word is `cfg_first` masked to the data width. Each following word is the previous word plus one, wrapping to 0 above the largest value the data width can hold.
- R6: A run sends exactly `cfg_count` frames. Consecutive frames are separated by one idle-high clock. `busy_o` falls one clock after the last frame ends.
- R7: With the start flag set, the start delay is skipped. A frame starts only at a boundary clock where `cts_i` is 1. Dropping `cts_i` during a frame does not shorten that frame.
- R8: A stop pulse during the start delay, or between frames, returns the block to idle at the next edge. A stop pulse during a frame lets the frame finish, and the block is idle from the edge that ends the frame.
- R9: `tx_o` is 1 whenever no frame is being sent.
- R10: First value, count, delay, divisor and frame format are captured at start. Changing them during a run does not alter the words or bit timing of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_first | input | 9 | Seed value of the first word |
| cfg_count | input | CNT_W | Number of words per run |
| cfg_delay_ns | input | DLY_W | Start delay in nanoseconds |
| cfg_baud_div | input | DIV_W | Clocks per bit |
| cfg_data_bits | input | 2 | Data width code |
| cfg_parity | input | 2 | Parity code |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| start_i | input | 1 | Start command pulse |
| start_fc_i | input | 1 | CTS gating enable, sampled with start |
| stop_i | input | 1 | Stop command pulse |
| cts_i | input | 1 | Clear to send, active high |
| tx_o | output | 1 | Serial transmit line |
| busy_o | output | 1 | Run in progress |

## Verification
Most internal faults show up on `tx_o` within one bit period, because the line is compared with a behavioural reference on every clock. A word that increments wrongly corrupts the data bits of the next frame. A wrong bit counter shifts the stop and parity positions. A miscounted delay or word counter moves the first start bit, or the edge where `busy_o` falls, by whole clocks. A sequencer that ignores CTS or stop shows up as a start bit in the wrong cycle, or as a frame cut short.

// File: rtl/uart_seq_pkg.sv
package uart_seq_pkg;

  localparam int MAX_DATA = 9;
  localparam int FRAME_W  = 13;  // start + 9 data + parity + 2 stop

  localparam logic [1:0] PAR_ODD  = 2'd1;
  localparam logic [1:0] PAR_EVEN = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2,
    ST_FRAME = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [1:0] dbits;
    logic [1:0] par;
    logic       two_stop;
  } frame_fmt_t;

  function automatic logic [3:0] seq_data_len(input logic [1:0] code);
    case (code)
      2'd0:    seq_data_len = 4'd7;
      2'd1:    seq_data_len = 4'd8;
      default: seq_data_len = 4'd9;
    endcase
  endfunction

  function automatic logic [MAX_DATA-1:0] seq_word_mask(input logic [1:0] code);
    case (code)
      2'd0:    seq_word_mask = 9'h07F;
      2'd1:    seq_word_mask = 9'h0FF;
      default: seq_word_mask = 9'h1FF;
    endcase
  endfunction

endpackage

// File: rtl/uart_seq_baud.sv
module uart_seq_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] div_eff;

  always_comb begin
    div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    tick_o  = en_i && (cnt_q == div_eff - DIV_W'(1));
  end

  always_comb begin
    cnt_n = cnt_q;
    if (restart_i)   cnt_n = '0;
    else if (tick_o) cnt_n = '0;
    else if (en_i)   cnt_n = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/uart_seq_frame.sv
module uart_seq_frame
  import uart_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [MAX_DATA-1:0] data_i,
  input  frame_fmt_t          fmt_i,
  input  logic                tick_i,
  output logic                tx_o,
  output logic                active_o,
  output logic                done_o
);

  logic [FRAME_W-1:0]  img;
  logic [MAX_DATA-1:0] dmask;
  logic [3:0]          dlen, nbits;
  logic                par_on, pbit;

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [3:0]         left_q, left_n;
  logic               act_q, act_n;
  logic               tx_q, tx_n;

  // frame image: bit 0 leaves first
  always_comb begin
    dlen   = seq_data_len(fmt_i.dbits);
    dmask  = data_i & seq_word_mask(fmt_i.dbits);
    par_on = (fmt_i.par == PAR_ODD) || (fmt_i.par == PAR_EVEN);
    pbit   = (^dmask) ^ (fmt_i.par == PAR_ODD);
    img    = '1;
    img[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (4'(i) < dlen) img[i+1] = dmask[i];
    end
    if (par_on) img[dlen + 4'd1] = pbit;
    nbits = 4'd2 + dlen + {3'b000, par_on} + {3'b000, fmt_i.two_stop};
  end

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    act_n  = act_q;
    tx_n   = tx_q;
    done_o = 1'b0;
    if (load_i) begin
      sh_n   = {1'b1, img[FRAME_W-1:1]};
      tx_n   = img[0];
      left_n = nbits - 4'd1;
      act_n  = 1'b1;
    end else if (act_q && tick_i) begin
      if (left_q == 4'd0) begin
        done_o = 1'b1;
        act_n  = 1'b0;
        tx_n   = 1'b1;
      end else begin
        tx_n   = sh_q[0];
        sh_n   = {1'b1, sh_q[FRAME_W-1:1]};
        left_n = left_q - 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      act_q  <= 1'b0;
      tx_q   <= 1'b1;
    end else begin
      sh_q   <= sh_n;
      left_q <= left_n;
      act_q  <= act_n;
      tx_q   <= tx_n;
    end
  end

  assign tx_o     = tx_q;
  assign active_o = act_q;

  // R4: a load from the sequencer puts the start bit on the line at once
  a_r4_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !tx_o);

endmodule

// File: rtl/uart_seq_ctrl.sv
module uart_seq_ctrl
  import uart_seq_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DLY_W         = 32,
  parameter int DIV_W         = 16,
  parameter int CLK_PERIOD_NS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_DATA-1:0] cfg_first,
  input  logic [CNT_W-1:0]    cfg_count,
  input  logic [DLY_W-1:0]    cfg_delay_ns,
  input  logic [DIV_W-1:0]    cfg_baud_div,
  input  frame_fmt_t          cfg_fmt,
  input  logic                start_i,
  input  logic                start_fc_i,
  input  logic                stop_i,
  input  logic                cts_i,
  input  logic                frame_active_i,
  input  logic                frame_done_i,
  output logic                load_o,
  output logic [MAX_DATA-1:0] word_o,
  output frame_fmt_t          fmt_o,
  output logic [DIV_W-1:0]    div_o,
  output logic                busy_o
);

  localparam logic [DLY_W-1:0] PERIOD_V = DLY_W'(CLK_PERIOD_NS);

  seq_state_e          state_q, state_n;
  logic [DLY_W-1:0]    wait_q, wait_n, dly_cycles;
  logic [CNT_W-1:0]    left_q, left_n;
  logic [MAX_DATA-1:0] word_q, word_n;
  logic                fc_q, fc_n;
  logic                stop_q, stop_n;
  frame_fmt_t          fmt_q, fmt_n;
  logic [DIV_W-1:0]    div_q, div_n;

  assign dly_cycles = cfg_delay_ns / PERIOD_V;

  always_comb begin
    state_n = state_q;
    wait_n  = wait_q;
    left_n  = left_q;
    word_n  = word_q;
    fc_n    = fc_q;
    stop_n  = stop_q;
    fmt_n   = fmt_q;
    div_n   = div_q;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && (cfg_count != '0)) begin
          fc_n   = start_fc_i;
          word_n = cfg_first & seq_word_mask(cfg_fmt.dbits);
          left_n = cfg_count;
          fmt_n  = cfg_fmt;
          div_n  = cfg_baud_div;
          stop_n = 1'b0;
          wait_n = dly_cycles;
          if (start_fc_i || (dly_cycles == '0)) state_n = ST_READY;
          else                                  state_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (stop_i)                      state_n = ST_IDLE;
        else if (wait_q <= DLY_W'(1))    state_n = ST_READY;
        else                             wait_n  = wait_q - DLY_W'(1);
      end
      ST_READY: begin
        if (stop_i || stop_q || (left_q == '0)) begin
          state_n = ST_IDLE;
          stop_n  = 1'b0;
        end else if (!fc_q || cts_i) begin
          load_o  = 1'b1;
          state_n = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (stop_i) stop_n = 1'b1;
        if (frame_done_i) begin
          word_n = (word_q + 9'd1) & seq_word_mask(fmt_q.dbits);
          left_n = left_q - CNT_W'(1);
          if (stop_i || stop_q) begin
            state_n = ST_IDLE;
            stop_n  = 1'b0;
          end else begin
            state_n = ST_READY;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      left_q  <= '0;
      word_q  <= '0;
      fc_q    <= 1'b0;
      stop_q  <= 1'b0;
      fmt_q   <= '0;
      div_q   <= '0;
    end else begin
      state_q <= state_n;
      wait_q  <= wait_n;
      left_q  <= left_n;
      word_q  <= word_n;
      fc_q    <= fc_n;
      stop_q  <= stop_n;
      fmt_q   <= fmt_n;
      div_q   <= div_n;
    end
  end

  assign word_o = word_q;
  assign fmt_o  = fmt_q;
  assign div_o  = div_q;
  assign busy_o = (state_q != ST_IDLE);

  // R7: under flow control a frame only leaves after CTS was high
  a_r7_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_active_i) && fc_q) |-> $past(cts_i));

  // R8: a stop during a frame does not cut the frame
  a_r8_stop_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && frame_active_i && !frame_done_i) |=> frame_active_i);

  // R2: a start with a zero count is ignored
  a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && start_i && (cfg_count == '0)) |=> !busy_o);

endmodule

// File: rtl/uart_seq_tx.sv
module uart_seq_tx
  import uart_seq_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DLY_W         = 32,
  parameter int DIV_W         = 16,
  parameter int CLK_PERIOD_NS = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_DATA-1:0] cfg_first,
  input  logic [CNT_W-1:0]    cfg_count,
  input  logic [DLY_W-1:0]    cfg_delay_ns,
  input  logic [DIV_W-1:0]    cfg_baud_div,
  input  logic [1:0]          cfg_data_bits,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                start_i,
  input  logic                start_fc_i,
  input  logic                stop_i,
  input  logic                cts_i,
  output logic                tx_o,
  output logic                busy_o
);

  frame_fmt_t          cfg_fmt, run_fmt;
  logic [MAX_DATA-1:0] word;
  logic [DIV_W-1:0]    run_div;
  logic                load, tick, f_active, f_done;

  assign cfg_fmt = '{dbits: cfg_data_bits, par: cfg_parity, two_stop: cfg_two_stop};

  uart_seq_ctrl #(
    .CNT_W(CNT_W), .DLY_W(DLY_W), .DIV_W(DIV_W), .CLK_PERIOD_NS(CLK_PERIOD_NS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_first(cfg_first), .cfg_count(cfg_count), .cfg_delay_ns(cfg_delay_ns),
    .cfg_baud_div(cfg_baud_div), .cfg_fmt(cfg_fmt),
    .start_i(start_i), .start_fc_i(start_fc_i), .stop_i(stop_i), .cts_i(cts_i),
    .frame_active_i(f_active), .frame_done_i(f_done),
    .load_o(load), .word_o(word), .fmt_o(run_fmt), .div_o(run_div), .busy_o(busy_o)
  );

  uart_seq_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .en_i(f_active), .restart_i(load),
    .div_i(run_div), .tick_o(tick)
  );

  uart_seq_frame u_frame (
    .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(word), .fmt_i(run_fmt),
    .tick_i(tick), .tx_o(tx_o), .active_o(f_active), .done_o(f_done)
  );

  // R9: line idles high whenever no run is active
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);

endmodule

// File: tb/uart_seq_tx_bench.sv
module uart_seq_tx_bench;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  cfg_first = '0;
  logic [15:0] cfg_count = '0;
  logic [31:0] cfg_delay_ns = '0;
  logic [15:0] cfg_baud_div = 16'd1;
  logic [1:0]  cfg_data_bits = 2'd1;
  logic [1:0]  cfg_parity = 2'd0;
  logic        cfg_two_stop = 1'b0;
  logic        start_i = 1'b0, start_fc_i = 1'b0, stop_i = 1'b0, cts_i = 1'b0;
  logic        tx, busy;

  always #(CLK_NS/2) clk = ~clk;

  uart_seq_tx #(.CLK_PERIOD_NS(CLK_NS)) u_uart_seq_tx (
    .clk(clk), .rst_n(rst_n), .cfg_first(cfg_first), .cfg_count(cfg_count),
    .cfg_delay_ns(cfg_delay_ns), .cfg_baud_div(cfg_baud_div),
    .cfg_data_bits(cfg_data_bits), .cfg_parity(cfg_parity),
    .cfg_two_stop(cfg_two_stop), .start_i(start_i), .start_fc_i(start_fc_i),
    .stop_i(stop_i), .cts_i(cts_i), .tx_o(tx), .busy_o(busy)
  );

  // ---------------- reference model ----------------
  int   m_phase = 0;  // 0 idle, 1 delay, 2 boundary, 3 frame
  int   m_wait, m_words, m_val, m_idx, m_tmr, m_n, m_div, m_dl, m_par;
  bit   m_fc, m_stop, m_two;
  logic m_tx = 1'b1;
  logic m_bits[13];

  task automatic build_frame();
    int ones = 0;
    m_n = 0;
    m_bits[m_n++] = 1'b0;
    for (int i = 0; i < m_dl; i++) begin
      m_bits[m_n++] = 1'((m_val >> i) & 1);
      ones += (m_val >> i) & 1;
    end
    if (m_par == 1) m_bits[m_n++] = 1'((ones % 2) == 0);
    if (m_par == 2) m_bits[m_n++] = 1'(ones % 2);
    m_bits[m_n++] = 1'b1;
    if (m_two) m_bits[m_n++] = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_tx = 1'b1; m_stop = 0;
    end else begin
      case (m_phase)
        0: if (start_i && cfg_count != 0) begin
             longint dly;
             m_dl   = (cfg_data_bits == 0) ? 7 : (cfg_data_bits == 1) ? 8 : 9;
             m_par  = cfg_parity;
             m_two  = cfg_two_stop;
             m_div  = (cfg_baud_div == 0) ? 1 : cfg_baud_div;
             m_val  = cfg_first % (1 << m_dl);
             m_words = cfg_count;
             m_fc   = start_fc_i;
             m_stop = 0;
             dly    = longint'(cfg_delay_ns) / CLK_NS;
             if (m_fc || dly == 0) m_phase = 2;
             else begin m_phase = 1; m_wait = int'(dly); end
           end
        1: if (stop_i) m_phase = 0;
           else if (m_wait == 1) m_phase = 2;
           else m_wait--;
        2: if (stop_i || m_stop || m_words == 0) begin
             m_phase = 0; m_stop = 0;
           end else if (!m_fc || cts_i) begin
             build_frame();
             m_idx = 0; m_tmr = 0; m_tx = m_bits[0]; m_phase = 3;
           end
        3: begin
             if (stop_i) m_stop = 1;
             m_tmr++;
             if (m_tmr == m_div) begin
               m_tmr = 0; m_idx++;
               if (m_idx == m_n) begin
                 m_tx = 1'b1;
                 m_val = (m_val + 1) % (1 << m_dl);
                 m_words--;
                 if (m_stop) begin m_phase = 0; m_stop = 0; end
                 else m_phase = 2;
               end else m_tx = m_bits[m_idx];
             end
           end
        default: m_phase = 0;
      endcase
    end
  end

  // ---------------- comparison ----------------
  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    cmp_en = 0, done_flag = 0;
  string cur_req = "R1";

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cmp_en && !done_flag) begin
      n_cmp++;
      if (tx !== m_tx || busy !== (m_phase != 0)) begin
        n_bad++;
        $display("FAIL %s cycle %0d: tx=%b busy=%b expected tx=%b busy=%b",
                 cur_req, cyc, tx, busy, m_tx, (m_phase != 0));
      end
    end
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected end before cycle 150000");
      summary();
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_cfg(input int first, input int cnt, input int dly,
                         input int div, input int db, input int par, input bit two);
    cfg_first = 9'(first); cfg_count = 16'(cnt); cfg_delay_ns = 32'(dly);
    cfg_baud_div = 16'(div); cfg_data_bits = 2'(db); cfg_parity = 2'(par);
    cfg_two_stop = two;
  endtask

  task automatic launch(input bit fc);
    @(negedge clk); start_i = 1'b1; start_fc_i = fc;
    @(negedge clk); start_i = 1'b0; start_fc_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_phase != 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R1: reset state, checked while reset is held and after release
    repeat (2) @(negedge clk);
    cmp_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5 R6: 8N1, delay of 5 clocks, three words
    cur_req = "R3 R4 R5 R6";
    set_cfg(16'h10, 3, 100, 4, 1, 0, 0);
    launch(0); wait_idle();

    // R4 R5: 7 data bits, even parity, wrap past 0x7F
    cur_req = "R4 R5";
    set_cfg(9'h0FE, 4, 0, 3, 0, 2, 0);
    launch(0); wait_idle();

    // R4 R5: 9 data bits, odd parity, two stop bits, wrap past 0x1FF
    cur_req = "R4 R5 R6";
    set_cfg(9'h1FE, 3, 40, 2, 2, 1, 1);
    launch(0); wait_idle();

    // R2: zero count ignored
    cur_req = "R2";
    set_cfg(5, 0, 0, 2, 1, 0, 0);
    launch(0); repeat (10) @(negedge clk);

    // R2 R10: start during a run and config changes have no effect
    cur_req = "R2 R10";
    set_cfg(9'h0A5, 2, 60, 3, 1, 1, 0);
    launch(0);
    repeat (12) @(negedge clk);
    set_cfg(9'h011, 7, 0, 1, 2, 2, 1);
    launch(0);
    wait_idle();

    // R7: CTS gating, delay skipped, CTS drop mid-frame
    cur_req = "R7";
    cts_i = 1'b0;
    set_cfg(9'h033, 3, 1000, 4, 1, 2, 0);
    launch(1);
    repeat (20) @(negedge clk);
    cts_i = 1'b1;
    repeat (8) @(negedge clk);
    cts_i = 1'b0;
    repeat (60) @(negedge clk);
    cts_i = 1'b1;
    wait_idle();

    // R8: stop during delay
    cur_req = "R8";
    set_cfg(1, 4, 2000, 2, 1, 0, 0);
    launch(0);
    repeat (10) @(negedge clk);
    pulse_stop(); wait_idle();

    // R8: stop in mid-frame
    cur_req = "R8 R9";
    set_cfg(9'h020, 5, 0, 4, 1, 0, 0);
    launch(0);
    repeat (22) @(negedge clk);
    pulse_stop(); wait_idle();

    // R8: stop at a boundary while CTS holds frames back
    cur_req = "R8 R7";
    cts_i = 1'b0;
    set_cfg(9'h040, 3, 0, 2, 1, 0, 0);
    launch(1);
    repeat (6) @(negedge clk);
    pulse_stop(); wait_idle();
    cts_i = 1'b1;

    // R3 R4: long delay of 250 us, divisor 0 acts as 1
    cur_req = "R3 R4";
    set_cfg(9'h07, 2, 250000, 0, 1, 0, 0);
    launch(0); wait_idle();

    done_flag = 1;
    summary();
  end

endmodule